// File: doc/BRIEF.md
# Significand Rounding Stage

This block takes a significand that still carries two precision bits below its
least significant stored bit, plus a sticky bit, and rounds it to its stored
width under one of four rounding modes. It is purely combinational and is meant
to sit at the tail of a floating-point adder, multiplier or format converter.
The caller has already aligned and normalized the value. The caller also handles
the exponent and any special operands.

The sign of the value is an input. This lets one incrementer serve both signs.
The directed modes turn their direction on the magnitude into "increment" or
"keep", depending on the sign. When the increment overflows the stored width,
the block raises a carry flag so the caller can shift right and bump the
exponent. A separate flag reports that precision was lost.

Top module: `fp_round_unit`

## Requirements
- R1: With mode 2'b00 (nearest, the default encoding), the magnitude is incremented by one LSB when the bits below the LSB are above half (guard=1 and round or sticky set), and kept when guard=0; the output never differs from the input by more than one LSB.
- R2: With mode 2'b00 and an exact half (guard=1, round=0, sticky=0), the result is the neighbour with LSB 0: an odd significand is incremented, an even one is kept.
- R3: With mode 2'b01 (toward zero), the significand passes unchanged and carry_o is 0 for every input.
- R4: With mode 2'b10 (toward +infinity), an inexact positive value (sign_i=0) is incremented and an inexact negative value (sign_i=1) is kept.
- R5: With mode 2'b11 (toward -infinity), an inexact negative value is incremented and an inexact positive value is kept.
- R6: When guard, round and sticky are all 0, the significand passes unchanged with carry_o=0 in every mode.
- R7: inexact_o is 1 exactly when at least one of guard, round or sticky is 1, independent of mode and sign.
- R8: When an all-ones significand is incremented, carry_o is 1 and sig_o is all zeros; carry_o is 0 in every other case.
- R9: In modes 2'b00 and 2'b01 the sign input has no effect on sig_o or carry_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sign_i | input | 1 | Sign of the value, 1 = negative |
| sig_i | input | SIG_W | Unrounded significand at stored width |
| guard_i | input | 1 | First bit below the LSB |
| round_i | input | 1 | Second bit below the LSB |
| sticky_i | input | 1 | OR of all lower discarded bits |
| mode_i | input | 2 | Rounding mode select |
| sig_o | output | SIG_W | Rounded significand |
| carry_o | output | 1 | Rounding overflowed the significand width |
| inexact_o | output | 1 | Discarded bits were nonzero |

## Verification
The bench targets the exact-half case with odd and even LSBs. A design that rounded half up would move even values, and one that ignored the tie would leave odd values unrounded. It uses a sticky bit set under an otherwise exact half to catch a design that treats round and sticky as a tie. It drives all-ones significands in every incrementing mode to expose a lost or misplaced carry. It sweeps both signs through the directed modes so that a swapped direction or a sign leaking into nearest or truncate shows up as a one-LSB error. A seeded random sweep over all inputs follows the directed cases.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_TO_ZERO   = 2'b01,
    RND_TO_POS    = 2'b10,
    RND_TO_NEG    = 2'b11
  } rnd_mode_e;

  typedef struct packed {
    logic guard;
    logic rnd;
    logic sticky;
  } tail_bits_t;

endpackage

// File: rtl/fp_round_decide.sv
module fp_round_decide
  import fp_round_pkg::*;
(
  input  logic       sign_i,
  input  logic       lsb_i,
  input  tail_bits_t tail_i,
  input  logic [1:0] mode_i,
  output logic       bump_o,
  output logic       lost_o
);

  rnd_mode_e mode_q;
  logic      any_below;
  logic      above_half;
  logic      exact_half;

  always_comb begin
    mode_q     = rnd_mode_e'(mode_i);
    any_below  = tail_i.guard | tail_i.rnd | tail_i.sticky;
    above_half = tail_i.guard & (tail_i.rnd | tail_i.sticky);
    exact_half = tail_i.guard & ~tail_i.rnd & ~tail_i.sticky;
    unique case (mode_q)
      RND_NEAR_EVEN: bump_o = above_half | (exact_half & lsb_i);
      RND_TO_ZERO:   bump_o = 1'b0;
      RND_TO_POS:    bump_o = any_below & ~sign_i;
      RND_TO_NEG:    bump_o = any_below & sign_i;
      default:       bump_o = 1'b0;
    endcase
    lost_o = any_below;
  end

  always_comb begin
    AST_NO_BUMP_WHEN_EXACT: assert (!(bump_o && !lost_o)) else $error("bump on exact value"); // R6
    AST_NEAR_LOW_HALF: assert (!(mode_q == RND_NEAR_EVEN && !tail_i.guard && bump_o)) else $error("bump below half"); // R1
  end

endmodule

// File: rtl/fp_round_incr.sv
module fp_round_incr #(
  parameter int unsigned WIDTH     = 24,
  parameter bit          USE_CHAIN = 1'b1
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  generate
    if (USE_CHAIN) begin : g_chain
      logic [WIDTH:0] cy;
      assign cy[0] = inc_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum_o[i]  = val_i[i] ^ cy[i];
        assign cy[i+1]   = val_i[i] & cy[i];
      end
      assign cout_o = cy[WIDTH];
    end else begin : g_adder
      logic [WIDTH:0] wide;
      assign wide   = {1'b0, val_i} + {{WIDTH{1'b0}}, inc_i};
      assign sum_o  = wide[WIDTH-1:0];
      assign cout_o = wide[WIDTH];
    end
  endgenerate

  always_comb begin
    AST_COUT_NEEDS_ONES: assert (!(cout_o && !(&val_i))) else $error("carry without all-ones"); // R8
    AST_COUT_ZERO_SUM: assert (!(cout_o && (|sum_o))) else $error("carry with nonzero sum"); // R8
  end

endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
  import fp_round_pkg::*;
#(
  parameter int unsigned SIG_W     = 24,
  parameter bit          USE_CHAIN = 1'b1
) (
  input  logic             sign_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic             guard_i,
  input  logic             round_i,
  input  logic             sticky_i,
  input  logic [1:0]       mode_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             carry_o,
  output logic             inexact_o
);

  localparam int unsigned EXT_W = SIG_W + 1;

  tail_bits_t tail;
  logic       bump;

  assign tail = '{guard: guard_i, rnd: round_i, sticky: sticky_i};

  fp_round_decide u_decide (
    .sign_i (sign_i),
    .lsb_i  (sig_i[0]),
    .tail_i (tail),
    .mode_i (mode_i),
    .bump_o (bump),
    .lost_o (inexact_o)
  );

  fp_round_incr #(
    .WIDTH     (SIG_W),
    .USE_CHAIN (USE_CHAIN)
  ) u_incr (
    .val_i  (sig_i),
    .inc_i  (bump),
    .sum_o  (sig_o),
    .cout_o (carry_o)
  );

  logic [EXT_W-1:0] diff;
  always_comb begin
    diff = {carry_o, sig_o} - {1'b0, sig_i};
    AST_ONE_LSB_STEP: assert (diff <= EXT_W'(1)) else $error("step above one LSB"); // R1
    AST_TRUNC_HOLDS: assert (!(mode_i == 2'b01 && (carry_o || sig_o != sig_i))) else $error("truncate changed value"); // R3
    AST_POS_NEG_KEEP: assert (!(mode_i == 2'b10 && sign_i && diff != '0)) else $error("up-mode moved negative"); // R4
    AST_NEG_POS_KEEP: assert (!(mode_i == 2'b11 && !sign_i && diff != '0)) else $error("down-mode moved positive"); // R5
    AST_EXACT_PASS: assert (!(!guard_i && !round_i && !sticky_i && diff != '0)) else $error("exact value moved"); // R6
  end

endmodule

// File: tb/fp_round_unit_tb.sv
module fp_round_unit_tb;

  localparam int W = 8;

  typedef struct {
    logic [W-1:0] sig;
    logic         cy;
    logic         inx;
    string        req;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic         sign_i, guard_i, round_i, sticky_i;
  logic [W-1:0] sig_i;
  logic [1:0]   mode_i;
  logic [W-1:0] sig_o;
  logic         carry_o, inexact_o;

  exp_t exp_q[$];
  int   n_vec;
  int   n_bad;
  bit   done;

  fp_round_unit #(.SIG_W(W), .USE_CHAIN(1'b1)) u_dut (
    .sign_i    (sign_i),
    .sig_i     (sig_i),
    .guard_i   (guard_i),
    .round_i   (round_i),
    .sticky_i  (sticky_i),
    .mode_i    (mode_i),
    .sig_o     (sig_o),
    .carry_o   (carry_o),
    .inexact_o (inexact_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Model written from the requirement text
  function automatic exp_t model(logic s, logic [W-1:0] v, logic g, logic r,
                                 logic k, logic [1:0] m, string req);
    exp_t e;
    logic up;
    logic lost;
    logic [W:0] sum;
    lost = g | r | k;
    case (m)
      2'b00: begin
        if (!g) up = 1'b0;
        else if (r | k) up = 1'b1;
        else up = v[0];
      end
      2'b01: up = 1'b0;
      2'b10: up = lost && !s;
      default: up = lost && s;
    endcase
    sum   = {1'b0, v} + (up ? 9'd1 : 9'd0);
    e.sig = sum[W-1:0];
    e.cy  = sum[W];
    e.inx = lost;
    e.req = req;
    return e;
  endfunction

  task automatic drive(logic s, logic [W-1:0] v, logic g, logic r, logic k,
                       logic [1:0] m, string req);
    @(posedge clk);
    sign_i = s; sig_i = v; guard_i = g; round_i = r; sticky_i = k; mode_i = m;
    exp_q.push_back(model(s, v, g, r, k, m, req));
  endtask

  // Monitor: compares each result half a cycle after it was driven
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (sig_o !== e.sig || carry_o !== e.cy || inexact_o !== e.inx) begin
        n_bad++;
        $display("FAIL %s: got sig=%h cy=%b inx=%b, expected sig=%h cy=%b inx=%b",
                 e.req, sig_o, carry_o, inexact_o, e.sig, e.cy, e.inx);
      end
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    sign_i = 0; sig_i = '0; guard_i = 0; round_i = 0; sticky_i = 0; mode_i = 2'b00;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Idle: zero in, zero out (R6)
    drive(0, 8'h00, 0, 0, 0, 2'b00, "R6");
    // R1 nearest: below half kept, above half rounded
    drive(0, 8'h10, 0, 1, 1, 2'b00, "R1");
    drive(0, 8'h10, 1, 1, 0, 2'b00, "R1");
    drive(1, 8'h10, 1, 0, 1, 2'b00, "R1");
    // R2 ties
    drive(0, 8'h11, 1, 0, 0, 2'b00, "R2");
    drive(0, 8'h12, 1, 0, 0, 2'b00, "R2");
    drive(1, 8'h13, 1, 0, 0, 2'b00, "R2");
    drive(1, 8'h14, 1, 0, 0, 2'b00, "R2");
    // R3 truncate
    drive(0, 8'hFF, 1, 1, 1, 2'b01, "R3");
    drive(1, 8'h37, 1, 0, 0, 2'b01, "R3");
    // R4 toward +inf
    drive(0, 8'h20, 0, 0, 1, 2'b10, "R4");
    drive(1, 8'h20, 1, 1, 1, 2'b10, "R4");
    // R5 toward -inf
    drive(1, 8'h20, 0, 1, 0, 2'b11, "R5");
    drive(0, 8'h20, 1, 1, 1, 2'b11, "R5");
    // R6 exact values in every mode
    for (int m = 0; m < 4; m++) begin
      drive(0, 8'hA5, 0, 0, 0, 2'(m), "R6");
      drive(1, 8'hFF, 0, 0, 0, 2'(m), "R6");
    end
    // R7 inexact from each tail bit alone
    drive(0, 8'h40, 1, 0, 0, 2'b01, "R7");
    drive(1, 8'h40, 0, 1, 0, 2'b11, "R7");
    drive(0, 8'h40, 0, 0, 1, 2'b10, "R7");
    // R8 overflow in each incrementing mode
    drive(0, 8'hFF, 1, 0, 0, 2'b00, "R8");
    drive(0, 8'hFF, 0, 0, 1, 2'b10, "R8");
    drive(1, 8'hFF, 0, 1, 0, 2'b11, "R8");
    drive(0, 8'hFE, 1, 0, 0, 2'b00, "R8");
    // R9 sign has no effect in nearest / truncate
    for (int s = 0; s < 2; s++) begin
      drive(1'(s), 8'h55, 1, 0, 0, 2'b00, "R9");
      drive(1'(s), 8'h56, 1, 1, 0, 2'b00, "R9");
      drive(1'(s), 8'h56, 1, 1, 0, 2'b01, "R9");
    end
    // Random sweep
    for (int i = 0; i < 2000; i++) begin
      logic [12:0] rv;
      rv = 13'($urandom);
      drive(rv[0], 8'($urandom), rv[1], rv[2], rv[3], rv[5:4], "R1");
    end

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule